// File: doc/BRIEF.md
# Two-by-two uncached link crossbar

This block joins two requesters to two responders on a lightweight uncached link. Each side has a request channel (A) and a response channel (D), and every channel moves data with a valid/ready handshake. A request is steered to a responder by the top bits of its address. A per-requester reachability mask is checked on the way. The requester's local source ID is widened into a shared ID space by ORing in that requester's base ID.

When both requesters want the same responder, the lower-numbered requester wins. A winner keeps the path for every beat of a multi-beat burst, and also for as long as a beat is stalled. Responses are sent back to the requester whose ID range holds the response source, with the base bits stripped. Each requester's D output takes at most one response burst at a time. A request that matches no responder, or only a responder the requester may not reach, never leaves the block. It is absorbed and answered locally with a denied response.

The address windows, reachability mask, data width and ID widths are fixed at elaboration.

Top module: `ul_xbar2x2`

## Requirements
- R1: A request whose address top four bits equal 0000 is forwarded to responder 0, and one whose top four bits equal 0001 goes to responder 1. Address, opcode, size and data pass through unchanged.
- R2: Requester 0 may reach both responders and requester 1 may reach only responder 1. A forbidden request is never presented on any responder A port.
- R3: A forwarded source is the local 4-bit source ORed with the requester base: requester 0 has base 0 and range [0,16), requester 1 has base 16 and range [16,32).
- R4: When both requesters present a request to the same idle responder, requester 0 is granted and requester 1 sees its ready low. Whenever an unlocked responder has any eligible request, one of them is presented.
- R5: A put (opcode 0 or 1) lasts max(1, 2^size/8) beats and a get (opcode 4) lasts one beat. Once a beat is shown to a responder, that responder stays with the same requester until the last beat completes its handshake, even while ready is low.
- R6: A response with source id satisfying 0 <= id < 16 goes to requester 0, and one with 16 <= id < 32 goes to requester 1. The returned source is the id minus that base.
- R7: A response burst with opcode 1 (data acknowledge) lasts max(1, 2^size/8) beats, and other responses last one beat. A requester's D output stays with one response burst until its last beat completes, and a competing responder sees ready low. When two responses arrive at once, responder 0 is taken first.
- R8: A request that matches no window, or only a forbidden one, has all its beats accepted. It is then answered locally with the denied bit set, sink 0 and data 0, with its source and size echoed. The opcode is 1 with the full beat count for a get, and 0 in one beat otherwise.
- R9: During and right after reset, with no inputs valid, no A or D valid is driven.
- R10: For a forwarded transaction, the response opcode, size, sink and data reach the requester unchanged, and the denied bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_a_valid | input | 2 | Requester A valid, one bit per requester |
| m_a_ready | output | 2 | Requester A ready |
| m_a_opcode | input | 2 x 3 | Requester A opcode (0/1 put, 4 get) |
| m_a_size | input | 2 x 4 | Log2 of transfer bytes |
| m_a_source | input | 2 x 4 | Local source ID |
| m_a_address | input | 2 x 32 | Byte address |
| m_a_data | input | 2 x 64 | Write data beat |
| m_d_valid | output | 2 | Requester D valid |
| m_d_ready | input | 2 | Requester D ready |
| m_d_opcode | output | 2 x 3 | Response opcode (0 ack, 1 data ack) |
| m_d_size | output | 2 x 4 | Echoed size |
| m_d_source | output | 2 x 4 | Restored local source ID |
| m_d_sink | output | 2 x 3 | Responder-chosen sink ID |
| m_d_denied | output | 2 | Set on locally generated error responses |
| m_d_data | output | 2 x 64 | Read data beat |
| s_a_valid | output | 2 | Responder A valid |
| s_a_ready | input | 2 | Responder A ready |
| s_a_opcode | output | 2 x 3 | Forwarded opcode |
| s_a_size | output | 2 x 4 | Forwarded size |
| s_a_source | output | 2 x 5 | Widened global source ID |
| s_a_address | output | 2 x 32 | Forwarded address |
| s_a_data | output | 2 x 64 | Forwarded data |
| s_d_valid | input | 2 | Responder D valid |
| s_d_ready | output | 2 | Responder D ready |
| s_d_opcode | input | 2 x 3 | Response opcode |
| s_d_size | input | 2 x 4 | Response size |
| s_d_source | input | 2 x 5 | Global source ID of the response |
| s_d_sink | input | 2 x 3 | Sink ID |
| s_d_data | input | 2 x 64 | Response data |

## Verification
A wrong burst counter or lock bit shows up within one beat. Either a waiting requester's source appears on a responder port in the middle of a burst, or a stalled beat is swapped for another one on the next edge. A wrong range test or base handling shows up in the same cycle as the response arrives, as a valid on the wrong requester or a source that still carries base bits. A stuck error engine shows up as a denied response that never appears after the last absorbed beat, or one that never retires after its last handshake.

// File: rtl/ul_xbar2x2.sv
module ul_xbar2x2 #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int SZW = 4,
  parameter int LSW = 4,
  parameter int SKW = 3,
  parameter int PFX = 4,
  parameter logic [2*PFX-1:0] SLV_TAGS = 8'h10,
  parameter logic [3:0] REACH = 4'b1011
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             m_a_valid,
  output logic [1:0]             m_a_ready,
  input  logic [1:0][2:0]        m_a_opcode,
  input  logic [1:0][SZW-1:0]    m_a_size,
  input  logic [1:0][LSW-1:0]    m_a_source,
  input  logic [1:0][AW-1:0]     m_a_address,
  input  logic [1:0][DW-1:0]     m_a_data,
  output logic [1:0]             m_d_valid,
  input  logic [1:0]             m_d_ready,
  output logic [1:0][2:0]        m_d_opcode,
  output logic [1:0][SZW-1:0]    m_d_size,
  output logic [1:0][LSW-1:0]    m_d_source,
  output logic [1:0][SKW-1:0]    m_d_sink,
  output logic [1:0]             m_d_denied,
  output logic [1:0][DW-1:0]     m_d_data,
  output logic [1:0]             s_a_valid,
  input  logic [1:0]             s_a_ready,
  output logic [1:0][2:0]        s_a_opcode,
  output logic [1:0][SZW-1:0]    s_a_size,
  output logic [1:0][LSW:0]      s_a_source,
  output logic [1:0][AW-1:0]     s_a_address,
  output logic [1:0][DW-1:0]     s_a_data,
  input  logic [1:0]             s_d_valid,
  output logic [1:0]             s_d_ready,
  input  logic [1:0][2:0]        s_d_opcode,
  input  logic [1:0][SZW-1:0]    s_d_size,
  input  logic [1:0][LSW:0]      s_d_source,
  input  logic [1:0][SKW-1:0]    s_d_sink,
  input  logic [1:0][DW-1:0]     s_d_data
);
  localparam int NM = 2;
  localparam int NS = 2;
  localparam int GSW = LSW + 1;
  localparam int DB = DW / 8;
  localparam int LDB = $clog2(DB);
  localparam int BCW = 1 << SZW;
  localparam logic [2:0] OP_PUTF = 3'd0;
  localparam logic [2:0] OP_PUTP = 3'd1;
  localparam logic [2:0] OP_GET  = 3'd4;
  localparam logic [2:0] OP_ACK  = 3'd0;
  localparam logic [2:0] OP_ACKD = 3'd1;
  localparam logic [1:0] E_IDLE = 2'd0;
  localparam logic [1:0] E_SINK = 2'd1;
  localparam logic [1:0] E_RESP = 2'd2;

  function automatic logic [BCW-1:0] burst_len(input logic [SZW-1:0] sz);
    logic [BCW-1:0] n;
    if (sz <= SZW'(LDB)) n = BCW'(1);
    else n = BCW'(1) << (sz - SZW'(LDB));
    return n;
  endfunction

  function automatic logic [BCW-1:0] a_beats(input logic [2:0] op, input logic [SZW-1:0] sz);
    return (op == OP_PUTF || op == OP_PUTP) ? burst_len(sz) : BCW'(1);
  endfunction

  function automatic logic [BCW-1:0] d_beats(input logic [2:0] op, input logic [SZW-1:0] sz);
    return (op == OP_ACKD) ? burst_len(sz) : BCW'(1);
  endfunction

  function automatic logic in_rng(input logic [GSW-1:0] id, input int m);
    return (int'(id) >= m * (1 << LSW)) && (int'(id) < (m + 1) * (1 << LSW));
  endfunction

  logic [NM-1:0][NS-1:0] ok;
  logic [NM-1:0]         bad;
  logic [NS-1:0][NM-1:0] a_req;
  logic [NS-1:0]         a_sel;
  logic [NS-1:0]         a_lock;
  logic [NM-1:0][1:0]    d_sel;
  logic [NM-1:0][2:0]    d_cand;

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      for (int s = 0; s < NS; s++) begin
        ok[m][s] = (m_a_address[m][AW-1 -: PFX] == SLV_TAGS[s*PFX +: PFX]) && REACH[m*NS+s];
        a_req[s][m] = m_a_valid[m] && ok[m][s];
      end
      bad[m] = m_a_valid[m] && !(|ok[m]);
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_slv
    logic           lock_q, own_q;
    logic [BCW-1:0] cnt_q, n_beats;

    assign a_sel[s]  = lock_q ? own_q : !a_req[s][0];
    assign a_lock[s] = lock_q;
    assign s_a_valid[s]   = a_req[s][a_sel[s]];
    assign s_a_opcode[s]  = m_a_opcode[a_sel[s]];
    assign s_a_size[s]    = m_a_size[a_sel[s]];
    assign s_a_address[s] = m_a_address[a_sel[s]];
    assign s_a_data[s]    = m_a_data[a_sel[s]];
    assign s_a_source[s]  = GSW'(m_a_source[a_sel[s]]) | (GSW'(a_sel[s]) << LSW);
    assign n_beats = a_beats(s_a_opcode[s], s_a_size[s]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q <= 1'b0;
        own_q  <= 1'b0;
        cnt_q  <= '0;
      end else if (!lock_q) begin
        if (s_a_valid[s] && !s_a_ready[s]) begin
          lock_q <= 1'b1;
          own_q  <= a_sel[s];
          cnt_q  <= n_beats;
        end else if (s_a_valid[s] && n_beats > BCW'(1)) begin
          lock_q <= 1'b1;
          own_q  <= a_sel[s];
          cnt_q  <= n_beats - BCW'(1);
        end
      end else if (s_a_valid[s] && s_a_ready[s]) begin
        if (cnt_q == BCW'(1)) lock_q <= 1'b0;
        else cnt_q <= cnt_q - BCW'(1);
      end
    end

    AST_SLV_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      s_a_valid[s] |-> s_a_address[s][AW-1 -: PFX] == SLV_TAGS[s*PFX +: PFX]); // R1
    AST_SLV_REACH: assert property (@(posedge clk) disable iff (!rst_n)
      s_a_valid[s] |-> REACH[{s_a_source[s][GSW-1:LSW], 1'(s)}]); // R2
    AST_A_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_lock[s] && |a_req[s]) |-> s_a_valid[s]); // R4
    AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (s_a_valid[s] && !s_a_ready[s]) |=> (s_a_valid[s] && $stable(s_a_source[s]) && $stable(s_a_address[s]))); // R5
  end

  for (genvar m = 0; m < NM; m++) begin : g_mst
    logic [1:0]     e_st;
    logic [2:0]     e_op;
    logic [SZW-1:0] e_sz;
    logic [LSW-1:0] e_src;
    logic [BCW-1:0] e_cnt;
    logic           e_take, e_fire;
    logic [2:0]     e_rop, cand;
    logic [1:0]     sel, own_q;
    logic           lock_q, d_fire;
    logic [BCW-1:0] cnt_q, n_beats;
    logic [2:0]     op;
    logic [SZW-1:0] sz;
    logic [LSW-1:0] src;
    logic [SKW-1:0] snk;
    logic [DW-1:0]  dat;
    logic           den;

    assign e_take = (e_st == E_IDLE && bad[m]) || (e_st == E_SINK && m_a_valid[m]);
    assign e_fire = e_take && m_a_valid[m];
    assign e_rop  = (e_op == OP_GET) ? OP_ACKD : OP_ACK;
    assign m_a_ready[m] = (a_req[0][m] && a_sel[0] == 1'(m) && s_a_ready[0]) ||
                          (a_req[1][m] && a_sel[1] == 1'(m) && s_a_ready[1]) || e_take;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_st  <= E_IDLE;
        e_op  <= '0;
        e_sz  <= '0;
        e_src <= '0;
        e_cnt <= '0;
      end else begin
        case (e_st)
          E_IDLE: if (e_fire) begin
            e_op  <= m_a_opcode[m];
            e_sz  <= m_a_size[m];
            e_src <= m_a_source[m];
            if (a_beats(m_a_opcode[m], m_a_size[m]) > BCW'(1)) begin
              e_st  <= E_SINK;
              e_cnt <= a_beats(m_a_opcode[m], m_a_size[m]) - BCW'(1);
            end else begin
              e_st  <= E_RESP;
              e_cnt <= d_beats((m_a_opcode[m] == OP_GET) ? OP_ACKD : OP_ACK, m_a_size[m]);
            end
          end
          E_SINK: if (e_fire) begin
            if (e_cnt == BCW'(1)) begin
              e_st  <= E_RESP;
              e_cnt <= d_beats(e_rop, e_sz);
            end else e_cnt <= e_cnt - BCW'(1);
          end
          E_RESP: if (d_fire && sel == 2'd2) begin
            if (e_cnt == BCW'(1)) e_st <= E_IDLE;
            else e_cnt <= e_cnt - BCW'(1);
          end
          default: e_st <= E_IDLE;
        endcase
      end
    end

    assign cand = {e_st == E_RESP,
                   s_d_valid[1] && in_rng(s_d_source[1], m),
                   s_d_valid[0] && in_rng(s_d_source[0], m)};
    assign sel = lock_q ? own_q : (cand[0] ? 2'd0 : (cand[1] ? 2'd1 : 2'd2));
    assign d_sel[m]  = sel;
    assign d_cand[m] = cand;

    always_comb begin
      if (sel == 2'd2) begin
        op  = e_rop;
        sz  = e_sz;
        src = e_src;
        snk = '0;
        dat = '0;
        den = 1'b1;
      end else begin
        op  = s_d_opcode[sel[0]];
        sz  = s_d_size[sel[0]];
        src = s_d_source[sel[0]][LSW-1:0];
        snk = s_d_sink[sel[0]];
        dat = s_d_data[sel[0]];
        den = 1'b0;
      end
    end

    assign m_d_valid[m]  = (sel == 2'd0 && cand[0]) || (sel == 2'd1 && cand[1]) || (sel == 2'd2 && cand[2]);
    assign m_d_opcode[m] = op;
    assign m_d_size[m]   = sz;
    assign m_d_source[m] = src;
    assign m_d_sink[m]   = snk;
    assign m_d_data[m]   = dat;
    assign m_d_denied[m] = den;
    assign d_fire  = m_d_valid[m] && m_d_ready[m];
    assign n_beats = d_beats(op, sz);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q <= 1'b0;
        own_q  <= 2'd0;
        cnt_q  <= '0;
      end else if (!lock_q) begin
        if (m_d_valid[m] && !m_d_ready[m]) begin
          lock_q <= 1'b1;
          own_q  <= sel;
          cnt_q  <= n_beats;
        end else if (d_fire && n_beats > BCW'(1)) begin
          lock_q <= 1'b1;
          own_q  <= sel;
          cnt_q  <= n_beats - BCW'(1);
        end
      end else if (d_fire) begin
        if (cnt_q == BCW'(1)) lock_q <= 1'b0;
        else cnt_q <= cnt_q - BCW'(1);
      end
    end

    AST_D_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_d_valid[m] && !m_d_ready[m]) |=> (m_d_valid[m] && $stable(m_d_source[m]) && $stable(m_d_denied[m]))); // R7
    AST_ERR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (e_st == E_SINK) |-> !(s_a_valid[0] && a_sel[0] == 1'(m)) && !(s_a_valid[1] && a_sel[1] == 1'(m))); // R8
  end

  for (genvar k = 0; k < NS; k++) begin : g_drdy
    logic r;
    always_comb begin
      r = 1'b0;
      for (int m = 0; m < NM; m++)
        if (d_cand[m][k] && d_sel[m] == 2'(k) && m_d_ready[m]) r = 1'b1;
    end
    assign s_d_ready[k] = r;
  end

endmodule

// File: tb/sim_ul_xbar2x2.sv
module sim_ul_xbar2x2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]        m_a_valid, m_a_ready, m_d_valid, m_d_ready, m_d_denied;
  logic [1:0][2:0]   m_a_opcode, m_d_opcode, s_a_opcode, s_d_opcode;
  logic [1:0][3:0]   m_a_size, m_d_size, s_a_size, s_d_size;
  logic [1:0][3:0]   m_a_source, m_d_source;
  logic [1:0][31:0]  m_a_address, s_a_address;
  logic [1:0][63:0]  m_a_data, m_d_data, s_a_data, s_d_data;
  logic [1:0][2:0]   m_d_sink, s_d_sink;
  logic [1:0]        s_a_valid, s_a_ready, s_d_valid, s_d_ready;
  logic [1:0][4:0]   s_a_source, s_d_source;

  ul_xbar2x2 u0 (
    .clk(clk), .rst_n(rst_n),
    .m_a_valid(m_a_valid), .m_a_ready(m_a_ready), .m_a_opcode(m_a_opcode), .m_a_size(m_a_size),
    .m_a_source(m_a_source), .m_a_address(m_a_address), .m_a_data(m_a_data),
    .m_d_valid(m_d_valid), .m_d_ready(m_d_ready), .m_d_opcode(m_d_opcode), .m_d_size(m_d_size),
    .m_d_source(m_d_source), .m_d_sink(m_d_sink), .m_d_denied(m_d_denied), .m_d_data(m_d_data),
    .s_a_valid(s_a_valid), .s_a_ready(s_a_ready), .s_a_opcode(s_a_opcode), .s_a_size(s_a_size),
    .s_a_source(s_a_source), .s_a_address(s_a_address), .s_a_data(s_a_data),
    .s_d_valid(s_d_valid), .s_d_ready(s_d_ready), .s_d_opcode(s_d_opcode), .s_d_size(s_d_size),
    .s_d_source(s_d_source), .s_d_sink(s_d_sink), .s_d_data(s_d_data)
  );

  typedef struct packed {
    logic        m;
    logic [2:0]  op;
    logic [3:0]  sz;
    logic [31:0] ad;
    logic [3:0]  src;
    logic [1:0]  ex;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0, 3'd4, 4'd3, 32'h0000_0100, 4'd2,  2'd0},
    '{1'b0, 3'd0, 4'd2, 32'h1000_0040, 4'd15, 2'd1},
    '{1'b1, 3'd4, 4'd3, 32'h1ABC_0000, 4'd0,  2'd1},
    '{1'b1, 3'd1, 4'd3, 32'h1FFF_FFF8, 4'd9,  2'd1},
    '{1'b1, 3'd4, 4'd2, 32'h0000_0010, 4'd4,  2'd2},
    '{1'b0, 3'd4, 4'd3, 32'h2000_0000, 4'd7,  2'd2},
    '{1'b0, 3'd0, 4'd0, 32'h0FFF_FFFF, 4'd1,  2'd0},
    '{1'b1, 3'd0, 4'd3, 32'hF000_0000, 4'd14, 2'd2}
  };

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic clear_all();
    m_a_valid = '0; m_a_opcode = '0; m_a_size = '0; m_a_source = '0; m_a_address = '0; m_a_data = '0;
    s_d_valid = '0; s_d_opcode = '0; s_d_size = '0; s_d_source = '0; s_d_sink = '0; s_d_data = '0;
  endtask

  task automatic put_a(input int m, input logic [2:0] op, input logic [3:0] sz,
                       input logic [31:0] ad, input logic [3:0] src);
    m_a_valid[m] = 1'b1; m_a_opcode[m] = op; m_a_size[m] = sz;
    m_a_address[m] = ad; m_a_source[m] = src; m_a_data[m] = {32'hA5A5_0000, ad};
  endtask

  task automatic put_d(input int s, input logic [2:0] op, input logic [3:0] sz,
                       input logic [4:0] src, input logic [2:0] snk, input logic [63:0] dat);
    s_d_valid[s] = 1'b1; s_d_opcode[s] = op; s_d_size[s] = sz;
    s_d_source[s] = src; s_d_sink[s] = snk; s_d_data[s] = dat;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    clear_all();
    s_a_ready = 2'b11;
    m_d_ready = 2'b11;
    repeat (3) @(negedge clk);
    chk("R9 reset s_a_valid", 64'(s_a_valid), 64'd0);
    chk("R9 reset m_d_valid", 64'(m_d_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after reset s_a_valid", 64'(s_a_valid), 64'd0);
    chk("R9 after reset m_d_valid", 64'(m_d_valid), 64'd0);

    for (int i = 0; i < 8; i++) begin
      vec_t v;
      logic [2:0] eop;
      v = TBL[i];
      eop = (v.op == 3'd4) ? 3'd1 : 3'd0;
      @(negedge clk);
      put_a(int'(v.m), v.op, v.sz, v.ad, v.src);
      #1;
      if (v.ex < 2) begin
        chk("R1 route", 64'(s_a_valid), 64'(2'b01 << v.ex));
        chk("R1 address", 64'(s_a_address[v.ex[0]]), 64'(v.ad));
        chk("R3 widened source", 64'(s_a_source[v.ex[0]]), 64'({v.m, v.src}));
      end else begin
        chk("R2 R8 not forwarded", 64'(s_a_valid), 64'd0);
      end
      chk("R1 a ready", 64'(m_a_ready[v.m]), 64'd1);
      @(negedge clk);
      m_a_valid = '0;
      if (v.ex < 2) put_d(int'(v.ex[0]), eop, v.sz, {v.m, v.src}, 3'(i), 64'hBEEF_0000_0000_0000 | 64'(i));
      #1;
      chk("R6 d route", 64'(m_d_valid), 64'(2'b01 << v.m));
      chk("R6 restored source", 64'(m_d_source[v.m]), 64'(v.src));
      chk("R10 R8 opcode", 64'(m_d_opcode[v.m]), 64'(eop));
      chk("R10 R8 size", 64'(m_d_size[v.m]), 64'(v.sz));
      chk("R10 R8 denied", 64'(m_d_denied[v.m]), 64'(v.ex == 2'd2));
      chk("R10 R8 sink", 64'(m_d_sink[v.m]), (v.ex < 2) ? 64'(i) : 64'd0);
      chk("R10 R8 data", m_d_data[v.m], (v.ex < 2) ? (64'hBEEF_0000_0000_0000 | 64'(i)) : 64'd0);
      @(negedge clk);
      s_d_valid = '0;
      #1;
      chk("R8 response retired", 64'(m_d_valid), 64'd0);
    end

    // R4 fixed priority
    @(negedge clk);
    put_a(0, 3'd4, 4'd3, 32'h1000_0000, 4'd1);
    put_a(1, 3'd4, 4'd3, 32'h1000_0008, 4'd2);
    #1;
    chk("R4 requester 0 wins", 64'(s_a_source[1]), 64'd1);
    chk("R4 loser ready low", 64'(m_a_ready), 64'b01);
    @(negedge clk);
    m_a_valid[0] = 1'b0;
    #1;
    chk("R4 requester 1 next", 64'(s_a_source[1]), 64'd18);
    chk("R4 requester 1 ready", 64'(m_a_ready[1]), 64'd1);
    @(negedge clk);
    clear_all();

    // R5 stalled single beat is held
    s_a_ready[1] = 1'b0;
    put_a(1, 3'd4, 4'd3, 32'h1000_0000, 4'd3);
    @(negedge clk);
    put_a(0, 3'd4, 4'd3, 32'h1000_0010, 4'd4);
    #1;
    chk("R5 stalled beat held", 64'(s_a_source[1]), 64'd19);
    chk("R5 waiter ready low", 64'(m_a_ready[0]), 64'd0);
    @(negedge clk);
    s_a_ready[1] = 1'b1;
    #1;
    chk("R5 held after stall", 64'(s_a_source[1]), 64'd19);
    @(negedge clk);
    m_a_valid[1] = 1'b0;
    #1;
    chk("R5 release to waiter", 64'(s_a_source[1]), 64'd4);
    @(negedge clk);
    clear_all();

    // R5 four-beat put burst locks out requester 0
    put_a(1, 3'd0, 4'd5, 32'h1000_0100, 4'd6);
    #1;
    chk("R5 burst first beat", 64'(s_a_source[1]), 64'd22);
    @(negedge clk);
    put_a(0, 3'd4, 4'd3, 32'h1000_0200, 4'd5);
    for (int b = 2; b <= 4; b++) begin
      m_a_data[1] = 64'(b);
      #1;
      chk("R5 burst beat owner", 64'(s_a_source[1]), 64'd22);
      chk("R5 burst waiter ready", 64'(m_a_ready[0]), 64'd0);
      @(negedge clk);
    end
    m_a_valid[1] = 1'b0;
    #1;
    chk("R5 after burst", 64'(s_a_source[1]), 64'd5);
    @(negedge clk);
    clear_all();

    // R6 range boundaries
    put_d(0, 3'd0, 4'd2, 5'd16, 3'd1, 64'd0);
    put_d(1, 3'd0, 4'd2, 5'd15, 3'd2, 64'd0);
    #1;
    chk("R6 both routed", 64'(m_d_valid), 64'b11);
    chk("R6 id 16 local", 64'(m_d_source[1]), 64'd0);
    chk("R6 id 15 local", 64'(m_d_source[0]), 64'd15);
    chk("R6 both ready", 64'(s_d_ready), 64'b11);
    @(negedge clk);
    clear_all();

    // R7 response burst lock
    put_d(1, 3'd1, 4'd5, 5'd2, 3'd3, 64'h11);
    #1;
    chk("R7 burst first beat", 64'(m_d_source[0]), 64'd2);
    @(negedge clk);
    put_d(0, 3'd0, 4'd2, 5'd3, 3'd4, 64'h0);
    for (int b = 2; b <= 4; b++) begin
      s_d_data[1] = 64'(b);
      #1;
      chk("R7 burst owner", 64'(m_d_source[0]), 64'd2);
      chk("R7 burst data", m_d_data[0], 64'(b));
      chk("R7 competitor ready low", 64'(s_d_ready[0]), 64'd0);
      @(negedge clk);
    end
    s_d_valid[1] = 1'b0;
    #1;
    chk("R7 competitor after burst", 64'(m_d_source[0]), 64'd3);
    chk("R7 competitor ready", 64'(s_d_ready[0]), 64'd1);
    @(negedge clk);
    clear_all();

    // R8 forbidden two-beat put
    put_a(1, 3'd0, 4'd4, 32'h0000_0000, 4'd9);
    #1;
    chk("R8 forbidden not forwarded", 64'(s_a_valid), 64'd0);
    chk("R8 beat 1 absorbed", 64'(m_a_ready[1]), 64'd1);
    @(negedge clk);
    chk("R8 beat 2 absorbed", 64'(m_a_ready[1]), 64'd1);
    chk("R8 no early response", 64'(m_d_valid[1]), 64'd0);
    @(negedge clk);
    m_a_valid = '0;
    #1;
    chk("R8 error response valid", 64'(m_d_valid[1]), 64'd1);
    chk("R8 error denied", 64'(m_d_denied[1]), 64'd1);
    chk("R8 error ack opcode", 64'(m_d_opcode[1]), 64'd0);
    chk("R8 error source", 64'(m_d_source[1]), 64'd9);
    @(negedge clk);
    #1;
    chk("R8 put error one beat", 64'(m_d_valid[1]), 64'd0);

    // R8 undecodable two-beat get response with stall
    @(negedge clk);
    put_a(0, 3'd4, 4'd4, 32'h3000_0000, 4'd12);
    #1;
    chk("R8 undecodable absorbed", 64'(m_a_ready[0]), 64'd1);
    @(negedge clk);
    m_a_valid = '0;
    m_d_ready[0] = 1'b0;
    #1;
    chk("R8 get error opcode", 64'(m_d_opcode[0]), 64'd1);
    chk("R8 get error source", 64'(m_d_source[0]), 64'd12);
    @(negedge clk);
    chk("R8 stalled error held", 64'(m_d_valid[0]), 64'd1);
    m_d_ready[0] = 1'b1;
    @(negedge clk);
    chk("R8 second error beat", 64'(m_d_valid[0]), 64'd1);
    @(negedge clk);
    chk("R8 get error retired", 64'(m_d_valid[0]), 64'd0);

    summary();
  end
endmodule